// File: doc/BRIEF.md
# Match-Triggered Output Controller

This block owns a small vector of external output bits. A timer's compare stage produces one pulse per channel when its count reaches a compare value. On such a pulse, the channel's own 2-bit action code decides what happens to that channel's output bit. The bit can stay as it is, go low, go high or invert. Each channel acts independently of the others. Software configures the action codes through one 32-bit control register. It can also set the output bits directly, either through that register or through a narrow write path that touches only the output bits.

All ports are plain control and status pins. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure. A write is taken in the cycle its enable is high. A match pulse is one cycle wide and is acted on in the cycle it is high.

Top module: `mtx_out_ctrl`

## Requirements
- R1: After reset, every output bit and every action code is 0, so `match_out` = 0 and `cfg_rdata` = 0x0000_0000.
- R2: Action code 00 (none) leaves the channel's output bit unchanged when its match pulse arrives and no software write targets that bit.
- R3: Action code 01 (clear) drives the channel's output bit to 0 in the cycle after its match pulse.
- R4: Action code 10 (set) drives the channel's output bit to 1 in the cycle after its match pulse.
- R5: Action code 11 (toggle) inverts the channel's output bit in the cycle after its match pulse, on every pulse.
- R6: The register layout is as follows. Bits 3:0 hold the output bits, with bit i for channel i. The action code of channel i sits in bits 4+2i+1 : 4+2i, so channel 0 uses 5:4 and channel 3 uses 11:10. Bits 31:12 ignore writes and always read as 0.
- R7: A register write (`cfg_we`) loads the action codes and output bits 3:0 in one cycle. A write on the direct path (`out_we`) loads only the output bits. When both write paths are active in the same cycle, the direct path wins for the output bits.
- R8: When a match pulse and a software write to a channel's output bit fall in the same cycle, a match with a non-none action decides the bit. A match whose action is none lets the write through.
- R9: A new action code takes effect from the cycle after its write. A match pulse in the same cycle as the write uses the previous code.
- R10: A match pulse on one channel never changes another channel's output bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| match_pulse | input | 4 | One-cycle match events, bit i for channel i |
| cfg_we | input | 1 | Control register write enable |
| cfg_wdata | input | 32 | Control register write data |
| cfg_rdata | output | 32 | Control register read value |
| out_we | input | 1 | Direct output-bit write enable |
| out_wdata | input | 4 | Direct output-bit write data |
| match_out | output | 4 | External match output bits |

## Verification
The assertions assume two things about the inputs. First, a match pulse lasts one cycle for each event. Second, no input changes near the active clock edge. The bench drives every input just after a rising edge and clears pulses after one cycle. The clear, set and toggle checks only need a match pulse and the stored action code. The hold check for the none code also requires that no write of either kind targets the bit in that cycle, and the stimulus covers both sides of that condition.

// File: rtl/mtx_pkg.sv
package mtx_pkg;
  localparam int unsigned NUM_CH  = 4;
  localparam int unsigned ACT_W   = 2;
  localparam int unsigned REG_W   = 32;
  localparam int unsigned ACT_LSB = NUM_CH;
  localparam int unsigned USED_W  = ACT_LSB + NUM_CH * ACT_W;

  typedef enum logic [ACT_W-1:0] {
    ACT_NONE = 2'b00,
    ACT_CLR  = 2'b01,
    ACT_SET  = 2'b10,
    ACT_TGL  = 2'b11
  } act_e;
endpackage

// File: rtl/mtx_action_reg.sv
module mtx_action_reg
  import mtx_pkg::*;
#(
  parameter int unsigned N_CH = NUM_CH
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [N_CH*ACT_W-1:0] wr_fields,
  output logic [N_CH*ACT_W-1:0] fields_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     fields_q <= '0;
    else if (wr_en) fields_q <= wr_fields;
  end

  // R9: codes move only on a register write
  a_r9_codes_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(fields_q));
endmodule

// File: rtl/mtx_channel.sv
module mtx_channel
  import mtx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic match_i,
  input  act_e act_i,
  input  logic sw_we_i,
  input  logic sw_val_i,
  output logic q_o
);
  logic q_nxt;
  logic match_live;

  assign match_live = match_i && (act_i != ACT_NONE);

  always_comb begin
    q_nxt = q_o;
    if (match_live) begin
      unique case (act_i)
        ACT_CLR: q_nxt = 1'b0;
        ACT_SET: q_nxt = 1'b1;
        ACT_TGL: q_nxt = ~q_o;
        default: q_nxt = q_o;
      endcase
    end else if (sw_we_i) begin
      q_nxt = sw_val_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= 1'b0;
    else        q_o <= q_nxt;
  end

  a_r3_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (match_i && act_i == ACT_CLR) |=> !q_o);
  a_r4_set: assert property (@(posedge clk) disable iff (!rst_n)
    (match_i && act_i == ACT_SET) |=> q_o);
  a_r5_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (match_i && act_i == ACT_TGL) |=> (q_o != $past(q_o)));
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (match_i && act_i == ACT_NONE && !sw_we_i) |=> $stable(q_o));
  a_r8_write_through: assert property (@(posedge clk) disable iff (!rst_n)
    (!match_live && sw_we_i) |=> (q_o == $past(sw_val_i)));
endmodule

// File: rtl/mtx_out_ctrl.sv
module mtx_out_ctrl
  import mtx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] match_pulse,
  input  logic              cfg_we,
  input  logic [REG_W-1:0]  cfg_wdata,
  output logic [REG_W-1:0]  cfg_rdata,
  input  logic              out_we,
  input  logic [NUM_CH-1:0] out_wdata,
  output logic [NUM_CH-1:0] match_out
);
  localparam int unsigned FLD_W = NUM_CH * ACT_W;

  logic [FLD_W-1:0]  fields_q;
  logic [NUM_CH-1:0] sw_we;
  logic [NUM_CH-1:0] sw_val;
  logic              unused_rsvd;

  assign unused_rsvd = ^cfg_wdata[REG_W-1:USED_W];

  mtx_action_reg #(.N_CH(NUM_CH)) u_act (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cfg_we),
    .wr_fields(cfg_wdata[USED_W-1:ACT_LSB]),
    .fields_q (fields_q)
  );

  // direct path outranks the register path for the output bits
  assign sw_we  = {NUM_CH{cfg_we | out_we}};
  assign sw_val = out_we ? out_wdata : cfg_wdata[NUM_CH-1:0];

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    mtx_channel u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .match_i (match_pulse[i]),
      .act_i   (act_e'(fields_q[i*ACT_W +: ACT_W])),
      .sw_we_i (sw_we[i]),
      .sw_val_i(sw_val[i]),
      .q_o     (match_out[i])
    );
  end

  always_comb begin
    cfg_rdata                     = '0;
    cfg_rdata[NUM_CH-1:0]         = match_out;
    cfg_rdata[USED_W-1:ACT_LSB]   = fields_q;
  end

  // R10: an idle channel with no write keeps its bit
  for (genvar k = 0; k < NUM_CH; k++) begin : g_iso
    a_r10_isolated: assert property (@(posedge clk) disable iff (!rst_n)
      (!match_pulse[k] && !cfg_we && !out_we) |=> $stable(match_out[k]));
  end
endmodule

// File: tb/mtx_out_ctrl_bench.sv
module mtx_out_ctrl_bench;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  match_pulse = '0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        out_we = 1'b0;
  logic [3:0]  out_wdata = '0;
  logic [3:0]  match_out;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mtx_out_ctrl u_mtx_out_ctrl (
    .clk(clk), .rst_n(rst_n), .match_pulse(match_pulse),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .out_we(out_we), .out_wdata(out_wdata), .match_out(match_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // apply one cycle of stimulus, then clear it just after the edge
  task automatic step(input logic [3:0] m, input logic cw, input logic [31:0] cd,
                      input logic ow, input logic [3:0] od);
    match_pulse = m; cfg_we = cw; cfg_wdata = cd; out_we = ow; out_wdata = od;
    @(posedge clk); #1;
    match_pulse = '0; cfg_we = 1'b0; cfg_wdata = '0; out_we = 1'b0; out_wdata = '0;
  endtask

  task automatic t_reset;
    check("R1 out", {28'd0, match_out}, 32'h0);
    check("R1 rdata", cfg_rdata, 32'h0);
  endtask

  task automatic t_set;
    step(4'h0, 1'b1, 32'h0000_0AA0, 1'b0, 4'h0);
    step(4'b0101, 1'b0, 32'h0, 1'b0, 4'h0);
    check("R4 set", {28'd0, match_out}, 32'h5);
    check("R10 untouched channels", cfg_rdata, 32'h0000_0AA5);
  endtask

  task automatic t_clear;
    step(4'h0, 1'b1, 32'h0000_055F, 1'b0, 4'h0);
    check("R7 cfg write outs", {28'd0, match_out}, 32'hF);
    step(4'b0011, 1'b0, 32'h0, 1'b0, 4'h0);
    check("R3 clear", {28'd0, match_out}, 32'hC);
  endtask

  task automatic t_toggle;
    step(4'h0, 1'b1, 32'h0000_0FF0, 1'b0, 4'h0);
    step(4'b1001, 1'b0, 32'h0, 1'b0, 4'h0);
    check("R5 toggle first", {28'd0, match_out}, 32'h9);
    step(4'b1111, 1'b0, 32'h0, 1'b0, 4'h0);
    check("R5 toggle second", {28'd0, match_out}, 32'h6);
  endtask

  task automatic t_none;
    step(4'h0, 1'b1, 32'h0000_0003, 1'b0, 4'h0);
    step(4'b1111, 1'b0, 32'h0, 1'b0, 4'h0);
    check("R2 none holds", {28'd0, match_out}, 32'h3);
  endtask

  task automatic t_reserved;
    step(4'h0, 1'b1, 32'hFFFF_F0A5, 1'b0, 4'h0);
    check("R6 reserved read zero", cfg_rdata, 32'h0000_00A5);
  endtask

  task automatic t_direct;
    step(4'h0, 1'b1, 32'h0000_0F05, 1'b1, 4'b1010);
    check("R7 direct wins", cfg_rdata, 32'h0000_0F0A);
    step(4'h0, 1'b0, 32'h0, 1'b1, 4'b0110);
    check("R7 direct only outs", cfg_rdata, 32'h0000_0F06);
  endtask

  task automatic t_priority;
    step(4'h0, 1'b1, 32'h0000_00D0, 1'b0, 4'h0);
    step(4'b1111, 1'b0, 32'h0, 1'b1, 4'b1111);
    check("R8 match beats write", {28'd0, match_out}, 32'hE);
  endtask

  task automatic t_timing;
    step(4'h0, 1'b1, 32'h0000_0FF0, 1'b0, 4'h0);
    step(4'b1111, 1'b1, 32'h0000_0550, 1'b0, 4'h0);
    check("R9 old code used", cfg_rdata, 32'h0000_055F);
    step(4'b1111, 1'b0, 32'h0, 1'b0, 4'h0);
    check("R9 new code used", {28'd0, match_out}, 32'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    rst_n = 1'b1;
    @(posedge clk); #1;
    t_reset();
    t_set();
    t_clear();
    t_toggle();
    t_none();
    t_reserved();
    t_direct();
    t_priority();
    t_timing();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule